// File: doc/BRIEF.md
# Configurable PCM Serial Audio Transmitter

The block turns stereo PCM sample pairs into a three-wire serial stream: a bit clock, a left/right word clock and one data line. The bit clock is made by dividing the system clock. A seven-bit runtime configuration word selects the precision (16, 18, 20 or 24 bits), which bit of each sample goes out first, and where the valid bits sit inside a 32-slot channel. It also sets the word-clock polarity, whether the first data bit trails the word-clock edge by one bit period or is aligned with it, and on which bit-clock edge the data changes.

Sample pairs enter through a valid/ready handshake into a one-pair holding buffer. The buffer is emptied into the shifter at each frame start, so a pair is accepted one frame ahead of the frame that carries it. A frame that starts with the buffer empty carries zeros and sets a sticky underrun flag, which software reads and clears through a small register port. A new configuration is copied into the serializer only at a frame start.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is held, and at power-up, the configuration register (address 0) reads 0x21. A write to address 0 stores wdata bits 6:0, and bit 7 always reads 0. A write to address 1 with bit 7 set restores 0x21.
- R2: Config bits 1:0 give the precision: 00 is 16 bits, 01 is 18, 10 is 20 and 11 is 24. A frame lasts 32 bit periods at 16 bits and 64 bit periods otherwise, with half of it spent in each channel. Input samples are right-aligned: the valid bits are bits W-1:0 of smp_left_i and smp_right_i.
- R3: Config bit 6 = 1 sends each sample least-significant bit first. With bit 6 = 0 the most-significant bit goes first.
- R4: At 18, 20 and 24 bits, config bit 5 = 0 places the W valid bits at the start of the 32-slot channel. Bit 5 = 1 places them at its end.
- R5: Config bit 4 = 1 drives the word clock low during the left channel and high during the right. Bit 4 = 0 reverses both levels. The word clock changes only on the bit-clock edge that launches data.
- R6: Config bit 3 = 0 puts the first data bit of each channel one bit period after the word-clock transition. Bit 3 = 1 puts it in the same bit period as the transition.
- R7: Config bit 2 = 0 changes data on the falling edge of bclk_o, so it is sampled on the rising edge. Bit 2 = 1 changes data on the rising edge.
- R8: Slots that carry no valid bit drive 0.
- R9: A configuration change takes effect only at the next frame start. A frame is never sent with two settings.
- R10: smp_ready_o is high exactly while the one-pair buffer is empty. An accepted pair is sent in the frame that starts after it was accepted. Pairs are sent in order, none is lost and none is repeated.
- R11: A frame that starts with the buffer empty sends all-zero data and sets the underrun flag, which is bit 0 of address 1. Writing address 1 with bit 0 set clears the flag. If a new underrun happens in the same cycle as the clear, the flag stays set.
- R12: The bit-clock period is 2*DIV_HALF system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_left_i | input | 24 | Left sample, right-aligned |
| smp_right_i | input | 24 | Right sample, right-aligned |
| smp_ready_o | output | 1 | Buffer empty, pair accepted on valid |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0: configuration, 1: status and command |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| bclk_o | output | 1 | Serial bit clock |
| wclk_o | output | 1 | Left/right word clock |
| sdata_o | output | 1 | Serial data |

## Verification
Two pairs of events can land in the same cycle. A software clear of the underrun flag can coincide with a frame start that finds the buffer empty, and a sample handshake can coincide with a frame start. The bench takes the frame start it observes on the word clock and counts one frame period forward to that exact edge. It places a clear write there and expects the flag to read 1 afterwards. A second clear, issued well clear of any frame start, is expected to read 0. The handshake case is judged by the decoded frames: each pushed pair must appear exactly once, in order.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int unsigned SMP_W  = 24;
  localparam int unsigned SLOT_W = 6;
  localparam logic [7:0]  CFG_RST = 8'h21;
  localparam logic        ADDR_CFG  = 1'b0;
  localparam logic        ADDR_STAT = 1'b1;

  typedef struct packed {
    logic       lsb_first;
    logic       pad_left;
    logic       wclk_i2s;
    logic       fmt_align;
    logic       edge_rise;
    logic [1:0] prec;
  } cfg_t;

  function automatic logic [SLOT_W-1:0] half_len(input logic [1:0] p);
    return (p == 2'b00) ? SLOT_W'(16) : SLOT_W'(32);
  endfunction

  function automatic logic [4:0] smp_width(input logic [1:0] p);
    case (p)
      2'b00:   return 5'd16;
      2'b01:   return 5'd18;
      2'b10:   return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

  // bit carried at frame position pos (already corrected for framing delay)
  function automatic logic slot_bit(input cfg_t c, input logic [SLOT_W-1:0] pos,
                                    input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
    logic [SLOT_W-1:0] h, idx, off, v;
    logic [4:0] w, b;
    logic ch;
    h   = half_len(c.prec);
    w   = smp_width(c.prec);
    ch  = (pos >= h);
    idx = ch ? pos - h : pos;
    off = (c.prec != 2'b00 && c.pad_left) ? h - SLOT_W'(w) : '0;
    if (idx < off || idx >= off + SLOT_W'(w)) return 1'b0;
    v = idx - off;
    b = c.lsb_first ? v[4:0] : w - 5'd1 - v[4:0];
    return ch ? r[b] : l[b];
  endfunction
endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic base_o,
  output logic tick_o,
  output logic launch_o
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o   = (cnt_q == CW'(DIV_HALF - 1));
  assign launch_o = tick_o & base_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_o <= 1'b0;
    end else if (tick_o) begin
      cnt_q  <= '0;
      base_o <= ~base_o;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/pcm_cfg_regs.sv
module pcm_cfg_regs
  import pcm_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  input  logic       ur_set_i,
  output cfg_t       cfg_o,
  output logic       ur_o,
  output logic [7:0] rdata_o
);
  logic [6:0] cfg_q;
  logic wr_cfg, wr_stat;

  assign wr_cfg  = we_i && (addr_i == ADDR_CFG);
  assign wr_stat = we_i && (addr_i == ADDR_STAT);
  assign cfg_o   = cfg_t'(cfg_q);
  assign rdata_o = (addr_i == ADDR_STAT) ? {7'b0, ur_o} : {1'b0, cfg_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST[6:0];
    end else if (wr_cfg) begin
      cfg_q <= wdata_i[6:0];
    end else if (wr_stat && wdata_i[7]) begin
      cfg_q <= CFG_RST[6:0];
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ur_o <= 1'b0;
    else if (ur_set_i)               ur_o <= 1'b1;
    else if (wr_stat && wdata_i[0])  ur_o <= 1'b0;
  end
endmodule

// File: rtl/pcm_frame_ser.sv
module pcm_frame_ser
  import pcm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              base_i,
  input  logic              launch_i,
  input  cfg_t              cfg_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_left_i,
  input  logic [SMP_W-1:0]  smp_right_i,
  output logic              smp_ready_o,
  output logic              ur_set_o,
  output cfg_t              act_cfg_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              bclk_o,
  output logic              wclk_o,
  output logic              sdata_o
);
  cfg_t act_q, act_n;
  logic [SLOT_W-1:0] slot_q, slot_n, last, h_n;
  logic [SMP_W-1:0]  l_q, r_q, l_n, r_n, bl_q, br_q;
  logic full_q, fstart, accept;
  logic wclk_n, sd_n, bclk_n;

  assign last        = SLOT_W'((7'(half_len(act_q.prec)) << 1) - 7'd1);
  assign fstart      = launch_i && (slot_q == last);
  assign accept      = smp_valid_i && !full_q;
  assign smp_ready_o = !full_q;
  assign ur_set_o    = fstart && !full_q;
  assign act_cfg_o   = act_q;
  assign slot_o      = slot_q;

  always_comb begin
    act_n  = act_q;
    slot_n = slot_q;
    l_n    = l_q;
    r_n    = r_q;
    if (fstart) begin
      act_n  = cfg_i;
      slot_n = '0;
      l_n    = full_q ? bl_q : '0;
      r_n    = full_q ? br_q : '0;
    end else if (launch_i) begin
      slot_n = slot_q + SLOT_W'(1);
    end
    h_n    = half_len(act_n.prec);
    wclk_n = ~((slot_n >= h_n) ^ act_n.wclk_i2s);
    // delayed framing: slot 0 carries the last bit of the previous frame
    if (!act_n.fmt_align && slot_n == '0)
      sd_n = act_q.fmt_align ? 1'b0 : slot_bit(act_q, last, l_q, r_q);
    else
      sd_n = slot_bit(act_n, slot_n - SLOT_W'(!act_n.fmt_align), l_n, r_n);
    bclk_n = (tick_i ? ~base_i : base_i) ^ act_n.edge_rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= cfg_t'(CFG_RST[6:0]);
      slot_q  <= SLOT_W'((7'(half_len(CFG_RST[1:0])) << 1) - 7'd1);
      l_q     <= '0;
      r_q     <= '0;
      wclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      bclk_o  <= 1'b0;
    end else begin
      act_q  <= act_n;
      slot_q <= slot_n;
      l_q    <= l_n;
      r_q    <= r_n;
      bclk_o <= bclk_n;
      if (launch_i) begin
        wclk_o  <= wclk_n;
        sdata_o <= sd_n;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      bl_q   <= '0;
      br_q   <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      bl_q   <= smp_left_i;
      br_q   <= smp_right_i;
    end else if (fstart) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  output logic             smp_ready_o,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             bclk_o,
  output logic             wclk_o,
  output logic             sdata_o
);
  logic base, tick, launch;
  logic ur_set, ur_q;
  cfg_t cfg, act_cfg;
  logic [SLOT_W-1:0] slot;

  pcm_bclk_gen #(.DIV_HALF(DIV_HALF)) u_bclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .base_o   (base),
    .tick_o   (tick),
    .launch_o (launch)
  );

  pcm_cfg_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .ur_set_i (ur_set),
    .cfg_o    (cfg),
    .ur_o     (ur_q),
    .rdata_o  (reg_rdata_o)
  );

  pcm_frame_ser u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .base_i      (base),
    .launch_i    (launch),
    .cfg_i       (cfg),
    .smp_valid_i (smp_valid_i),
    .smp_left_i  (smp_left_i),
    .smp_right_i (smp_right_i),
    .smp_ready_o (smp_ready_o),
    .ur_set_o    (ur_set),
    .act_cfg_o   (act_cfg),
    .slot_o      (slot),
    .bclk_o      (bclk_o),
    .wclk_o      (wclk_o),
    .sdata_o     (sdata_o)
  );
endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk
  import pcm_tx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              smp_ready_o,
  input logic              bclk_o,
  input logic              wclk_o,
  input logic              sdata_o,
  input cfg_t              act_cfg,
  input logic [SLOT_W-1:0] slot,
  input logic              ur_set,
  input logic              ur_q
);
  p_rdy_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o);

  p_data_launch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> (bclk_o == act_cfg.edge_rise));

  p_wclk_launch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wclk_o) |-> (bclk_o == act_cfg.edge_rise));

  p_cfg_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_cfg) |-> (slot == '0));

  p_ur_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ur_set |=> ur_q);
endmodule

bind pcm_serial_tx pcm_serial_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_ready_o (smp_ready_o),
  .bclk_o      (bclk_o),
  .wclk_o      (wclk_o),
  .sdata_o     (sdata_o),
  .act_cfg     (act_cfg),
  .slot        (slot),
  .ur_set      (ur_set),
  .ur_q        (ur_q)
);

// File: tb/pcm_serial_tx_tb_top.sv
`timescale 1ns/100ps
module pcm_serial_tx_tb_top;
  localparam int DIV_HALF = 2;
  localparam int REC_MAX  = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [23:0] smp_l = '0, smp_r = '0;
  logic smp_ready;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic bclk, wclk, sdata;

  always #2.5 clk = ~clk;

  pcm_serial_tx #(.DIV_HALF(DIV_HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_left_i(smp_l),
    .smp_right_i(smp_r), .smp_ready_o(smp_ready), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bclk_o(bclk), .wclk_o(wclk), .sdata_o(sdata)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // receiver model: capture at the sampling edge of the active setting
  bit rec_en = 0, seg_edge = 0;
  logic rec_w [REC_MAX];
  logic rec_d [REC_MAX];
  int   rec_t [REC_MAX];
  int   rec_n = 0, edge_bad = 0, cyc = 0;
  logic pb = 1'b0, psd = 1'b0;

  always @(negedge clk) begin
    bit chg, samp;
    cyc++;
    chg  = (bclk != pb);
    samp = chg && (bclk == !seg_edge);
    if (rec_en) begin
      if (samp && rec_n < REC_MAX) begin
        rec_w[rec_n] = wclk; rec_d[rec_n] = sdata; rec_t[rec_n] = cyc; rec_n++;
      end
      if (sdata != psd && !(chg && bclk == seg_edge)) edge_bad++;
    end
    pb = bclk; psd = sdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int f_half(input logic [7:0] c); return (c[1:0] == 0) ? 16 : 32; endfunction
  function automatic int f_width(input logic [7:0] c);
    case (c[1:0]) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    do @(negedge clk); while (!smp_ready);
    smp_valid = 1; smp_l = l; smp_r = r;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic wait_left(input logic lvl);
    logic p;
    do begin p = wclk; @(negedge clk); end while (!(p != lvl && wclk == lvl));
  endtask

  logic [23:0] exp_l [4];
  logic [23:0] exp_r [4];

  task automatic analyze(input logic [7:0] c, input int np);
    int h, w, off, d, k, pos;
    logic lvl, b;
    logic [23:0] vl, vr;
    bit ok, padok, per_ok;
    h = f_half(c); w = f_width(c);
    off = (h == 32 && c[5]) ? h - w : 0;
    d = c[3] ? 0 : 1;
    lvl = c[4] ? 1'b0 : 1'b1;
    k = 0;
    for (int f = 1; f + 2*h + 1 < rec_n; f++) begin
      if (rec_w[f] == lvl && rec_w[f-1] != lvl) begin
        ok = 1;
        for (int s = 0; s < 2*h; s++)
          if (rec_w[f+s] != ((s < h) ? lvl : !lvl)) ok = 0;
        check(ok, "R2 R5 word clock shape", int'(c), int'(h));
        vl = '0; vr = '0; padok = 1;
        for (int ch = 0; ch < 2; ch++)
          for (int i = 0; i < h; i++) begin
            b = rec_d[f + ch*h + i + d];
            if (i >= off && i < off + w) begin
              pos = c[6] ? (i - off) : (w - 1 - (i - off));
              if (ch == 1) vr[pos] = b; else vl[pos] = b;
            end else if (b) padok = 0;
          end
        check(padok, "R4 R8 unused slots zero", int'(c), 0);
        if (vl != 0) begin
          if (k < np)
            check(vl == exp_l[k] && vr == exp_r[k], "R3 R4 R6 R10 sample", int'(vl), int'(exp_l[k]));
          k++;
        end else begin
          check(vr == 0, "R11 underrun frame zero", int'(vr), 0);
        end
      end
    end
    check(k == np, "R10 pairs delivered once", k, np);
    per_ok = 1;
    for (int i = 1; i < rec_n; i++) if (rec_t[i] - rec_t[i-1] != 2*DIV_HALF) per_ok = 0;
    check(per_ok, "R12 bit clock period", 0, 2*DIV_HALF);
    check(edge_bad == 0, "R7 data launch edge", edge_bad, 0);
  endtask

  task automatic segment(input logic [7:0] c);
    int w;
    logic [23:0] m;
    logic [7:0] st;
    w = f_width(c);
    m = 24'((32'd1 << w) - 1);
    wr(1'b0, c);
    repeat (700) @(negedge clk);
    seg_edge = c[2]; rec_n = 0; edge_bad = 0; pb = bclk; psd = sdata; rec_en = 1;
    for (int i = 0; i < 4; i++) begin
      exp_l[i] = (24'($urandom) & m) | 24'd1;
      exp_r[i] = 24'($urandom) & m;
      push(exp_l[i], exp_r[i]);
    end
    repeat (900) @(negedge clk);
    rec_en = 0;
    analyze(c, 4);
    rd(1'b1, st);
    check(st[0] == 1'b1, "R11 sticky underrun", int'(st), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int starts [64];
    int ns;
    bit seen64, order_ok, len_ok;
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    check(bclk == 0 && wclk == 0 && sdata == 0, "R1 reset outputs", {bclk, wclk, sdata}, 0);
    check(smp_ready == 1, "R10 ready after reset", smp_ready, 1);
    rd(1'b0, v); check(v == 8'h21, "R1 config reset", v, 8'h21);
    rd(1'b1, v); check(v == 8'h00, "R11 flag reset", v, 0);
    @(negedge clk); rst_n = 1;

    wr(1'b0, 8'hFF); rd(1'b0, v); check(v == 8'h7F, "R1 bit7 reads zero", v, 8'h7F);
    wr(1'b1, 8'h80); rd(1'b0, v); check(v == 8'h21, "R1 software reset", v, 8'h21);

    segment(8'h21);
    segment(8'h7B);
    segment(8'h14);
    segment(8'h4E);
    segment(8'h60);
    for (int i = 0; i < 4; i++) segment(8'($urandom) & 8'h7F);

    // R9: precision change mid-frame, frame lengths must switch cleanly
    wr(1'b0, 8'h00);
    repeat (700) @(negedge clk);
    seg_edge = 0; rec_n = 0; pb = bclk; psd = sdata; rec_en = 1;
    repeat (300) @(negedge clk);
    wr(1'b0, 8'h03);
    repeat (1200) @(negedge clk);
    rec_en = 0;
    ns = 0;
    for (int f = 1; f < rec_n; f++)
      if (rec_w[f] == 1 && rec_w[f-1] == 0 && ns < 64) begin starts[ns] = f; ns++; end
    seen64 = 0; order_ok = 1; len_ok = 1;
    for (int i = 1; i < ns; i++) begin
      if (starts[i] - starts[i-1] == 64) seen64 = 1;
      else if (starts[i] - starts[i-1] == 32) begin if (seen64) order_ok = 0; end
      else len_ok = 0;
    end
    check(len_ok && order_ok && seen64 && ns > 3 && starts[1] - starts[0] == 32,
          "R9 R2 frame length switch", starts[1] - starts[0], 32);

    // R11: clear away from a frame start, then clear colliding with one
    wait_left(1'b1);
    wr(1'b1, 8'h01);
    rd(1'b1, v); check(v[0] == 1'b0, "R11 clear", v, 0);
    wait_left(1'b1);
    repeat (64*2*DIV_HALF - 1) @(negedge clk);
    reg_we = 1; reg_addr = 1'b1; reg_wdata = 8'h01;
    @(negedge clk); reg_we = 0;
    rd(1'b1, v); check(v[0] == 1'b1, "R11 set wins over clear", v, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule